// File: doc/BRIEF.md
# Display Path Flush Control Register Block

This block is the register front end of one display compositing path. Software writes flush request bits for source pipes, mixers, post-processing units, 3D merge units and output interfaces into a main flush word. It writes per-interface and per-merge unit selections into two separate sub-mask registers. The pending bits drive downstream logic continuously. When the frame boundary input pulses, the block retires everything pending and emits a one-cycle strobe that carries the mask it applied.

The flush is two-level. Bit 31 of the flush word enables the interface sub-mask and bit 23 enables the merge sub-mask. A sub-mask reaches downstream logic only while its summary bit is pending. The block also holds a top configuration word, with bit 17 selecting command mode, and registers for active interfaces, active merge units, active fetch pipes and the interface master. Start and prepare are write-one trigger registers that produce one-cycle pulses.

A self-clearing software reset wipes all pending flush state. While it runs, the reset status reads busy for a fixed number of clock cycles, and writes to flush, the sub-masks and start are ignored during that time. Access is through a simple register bus with write and read strobes, a byte address and 32-bit data. Read data is registered.

Top module: `flush_ctl`

## Requirements
- R1: After reset, every stored register, every pending bit and every pulse output is zero, and a read of the flush word at 0x018 returns 0.
- R2: A write to the flush word at 0x018 ORs the written value into the pending bits. Pending bits accumulate across writes, and a read of 0x018 returns the current pending bits.
- R3: A flush write that sets any mixer bit (bits 6 to 10 or bit 20) also sets control-path bit 17 in the pending bits.
- R4: The interface sub-mask at 0x110 and the merge sub-mask at 0x100 accumulate by OR, with bit i standing for unit i, and read back raw. Output pendingIntf equals the interface sub-mask while pending bit 31 is set and is zero otherwise. Output pendingMerge equals the merge sub-mask while pending bit 23 is set and is zero otherwise.
- R5: One cycle after frameDone is sampled high with nonzero pending bits, flushApply is high for exactly one cycle. In that cycle appliedFlush holds the retired bits, and appliedIntf and appliedMerge hold the gated sub-masks. Pending bits and both sub-masks are zero in the same cycle. A frameDone with nothing pending produces no strobe.
- R6: A flush write in the same cycle as frameDone is not retired: it becomes the only pending content of the next frame.
- R7: A write to start (0x01C) or prepare (0x0D0) with bit 0 set gives a one-cycle pulse on startPulse or preparePulse in the following cycle. A write with bit 0 clear gives no pulse, and both addresses read as 0.
- R8: The top configuration word at 0x014 is stored in full and read back. Output cmdMode is its bit 17 (1 for command mode, 0 for video mode).
- R9: The interface-active (0x0F4, NUM_INTF bits), merge-active (0x0E4, NUM_MERGE bits), fetch-active (0x0FC, 32 bits) and interface-master (0x134, 32 bits) registers store their low bits, read them back and drive them on their outputs.
- R10: Writing 1 to bit 0 of the reset register at 0x030 raises resetBusy for exactly RESET_CYCLES cycles and clears the pending bits and both sub-masks. Bit 0 of 0x030 reads resetBusy.
- R11: While resetBusy is high, writes to the flush word, the sub-masks and start have no effect, while prepare still pulses. Once resetBusy falls, flush writes take effect again.
- R12: Read data appears on busRdata in the cycle after busRd, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| frameDone | input | 1 | Frame boundary pulse, retires pending flush |
| pendingFlush | output | 32 | Pending main flush bits |
| pendingIntf | output | NUM_INTF | Interface sub-mask, gated by pending bit 31 |
| pendingMerge | output | NUM_MERGE | Merge sub-mask, gated by pending bit 23 |
| flushApply | output | 1 | One-cycle strobe when a flush is retired |
| appliedFlush | output | 32 | Main bits retired at the last strobe |
| appliedIntf | output | NUM_INTF | Gated interface sub-mask retired at the last strobe |
| appliedMerge | output | NUM_MERGE | Gated merge sub-mask retired at the last strobe |
| startPulse | output | 1 | One-cycle start trigger |
| preparePulse | output | 1 | One-cycle prepare trigger |
| resetBusy | output | 1 | Software reset in progress |
| cmdMode | output | 1 | Command mode selected (top configuration bit 17) |
| intfActive | output | NUM_INTF | Active interface set |
| mergeActive | output | NUM_MERGE | Active merge unit set |
| fetchActive | output | 32 | Active fetch pipe set |
| intfMaster | output | 32 | Interface master register |

## Verification
The assertions check several properties on every cycle. Pending bits never drop except on a retire or a reset, and a pending mixer bit always comes with control bit 17. Gated sub-mask outputs never appear without their summary bit, and the pending state stays empty for as long as resetBusy is high. Start pulses never follow a busy cycle. Only the bench scenarios can show the exact values involved: the bit values that are retired and returned by reads, the exact length of the busy window, the same-cycle race between a flush write and frameDone, and the registers that store only some of the written bits.

// File: rtl/flush_ctl_pkg.sv
package flush_ctl_pkg;

  localparam int REG_W = 32;

  localparam logic [11:0] OFF_TOP       = 12'h014;
  localparam logic [11:0] OFF_FLUSH     = 12'h018;
  localparam logic [11:0] OFF_START     = 12'h01C;
  localparam logic [11:0] OFF_SWRST     = 12'h030;
  localparam logic [11:0] OFF_PREPARE   = 12'h0D0;
  localparam logic [11:0] OFF_MERGE_ACT = 12'h0E4;
  localparam logic [11:0] OFF_INTF_ACT  = 12'h0F4;
  localparam logic [11:0] OFF_FETCH_ACT = 12'h0FC;
  localparam logic [11:0] OFF_MERGE_SUB = 12'h100;
  localparam logic [11:0] OFF_INTF_SUB  = 12'h110;
  localparam logic [11:0] OFF_MASTER    = 12'h134;

  localparam int MERGE_SUM_BIT = 23;
  localparam int INTF_SUM_BIT  = 31;
  localparam int CTL_PATH_BIT  = 17;
  localparam int CMD_MODE_BIT  = 17;

  // mixers 0..4 on bits 6..10, mixer 5 on bit 20
  localparam logic [REG_W-1:0] MIXER_MASK = 32'h0010_07C0;

  typedef struct packed {
    logic wrTop;
    logic wrFlush;
    logic wrIntfSub;
    logic wrMergeSub;
    logic wrIntfAct;
    logic wrMergeAct;
    logic wrFetch;
    logic wrMaster;
    logic retire;
    logic clearAll;
  } strobes_t;

endpackage

// File: rtl/flush_ctl_ctrl.sv
module flush_ctl_ctrl
  import flush_ctl_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int RESET_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrBit0,
  input  logic              frameDone,
  output strobes_t          st,
  output logic              resetBusy,
  output logic              startPulse,
  output logic              preparePulse
);

  localparam int CNT_W = $clog2(RESET_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;
  logic hitTop, hitFlush, hitStart, hitReset, hitPrep;
  logic hitMergeAct, hitIntfAct, hitFetch, hitMergeSub, hitIntfSub, hitMaster;

  always_comb begin
    hitTop      = busWr && (busAddr == ADDR_W'(OFF_TOP));
    hitFlush    = busWr && (busAddr == ADDR_W'(OFF_FLUSH));
    hitStart    = busWr && (busAddr == ADDR_W'(OFF_START));
    hitReset    = busWr && (busAddr == ADDR_W'(OFF_SWRST));
    hitPrep     = busWr && (busAddr == ADDR_W'(OFF_PREPARE));
    hitMergeAct = busWr && (busAddr == ADDR_W'(OFF_MERGE_ACT));
    hitIntfAct  = busWr && (busAddr == ADDR_W'(OFF_INTF_ACT));
    hitFetch    = busWr && (busAddr == ADDR_W'(OFF_FETCH_ACT));
    hitMergeSub = busWr && (busAddr == ADDR_W'(OFF_MERGE_SUB));
    hitIntfSub  = busWr && (busAddr == ADDR_W'(OFF_INTF_SUB));
    hitMaster   = busWr && (busAddr == ADDR_W'(OFF_MASTER));
  end

  always_comb begin
    st            = '0;
    st.wrTop      = hitTop;
    st.wrFlush    = hitFlush && !resetBusy;
    st.wrIntfSub  = hitIntfSub && !resetBusy;
    st.wrMergeSub = hitMergeSub && !resetBusy;
    st.wrIntfAct  = hitIntfAct;
    st.wrMergeAct = hitMergeAct;
    st.wrFetch    = hitFetch;
    st.wrMaster   = hitMaster;
    st.retire     = frameDone;
    st.clearAll   = hitReset && wrBit0 && !resetBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resetBusy <= 1'b0;
      busyCnt   <= '0;
    end else if (st.clearAll) begin
      resetBusy <= 1'b1;
      busyCnt   <= CNT_W'(RESET_CYCLES - 1);
    end else if (resetBusy) begin
      if (busyCnt == '0) resetBusy <= 1'b0;
      else               busyCnt   <= busyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPulse   <= 1'b0;
      preparePulse <= 1'b0;
    end else begin
      startPulse   <= hitStart && wrBit0 && !resetBusy;
      preparePulse <= hitPrep && wrBit0;
    end
  end

  // R7/R11: a start pulse never follows a busy cycle
  a_r11_start_needs_idle: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> !$past(resetBusy));

  // R10: busy only rises after a write to the reset register
  a_r10_busy_from_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetBusy) |-> ($past(busWr) && $past(busAddr) == ADDR_W'(OFF_SWRST)));

  // R7: pulses last one cycle unless rewritten
  a_r7_prepare_single: assert property (@(posedge clk) disable iff (!rstN)
    preparePulse |-> $past(busWr));

endmodule

// File: rtl/flush_ctl_dp.sv
module flush_ctl_dp
  import flush_ctl_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_INTF  = 8,
  parameter int NUM_MERGE = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             st,
  input  logic [REG_W-1:0]     wdata,
  input  logic                 busRd,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 resetBusy,
  output logic [REG_W-1:0]     busRdata,
  output logic [REG_W-1:0]     pendingFlush,
  output logic [NUM_INTF-1:0]  pendingIntf,
  output logic [NUM_MERGE-1:0] pendingMerge,
  output logic                 flushApply,
  output logic [REG_W-1:0]     appliedFlush,
  output logic [NUM_INTF-1:0]  appliedIntf,
  output logic [NUM_MERGE-1:0] appliedMerge,
  output logic                 cmdMode,
  output logic [NUM_INTF-1:0]  intfActive,
  output logic [NUM_MERGE-1:0] mergeActive,
  output logic [REG_W-1:0]     fetchActive,
  output logic [REG_W-1:0]     intfMaster
);

  logic [REG_W-1:0]     topCfg;
  logic [NUM_INTF-1:0]  intfSub;
  logic [NUM_MERGE-1:0] mergeSub;
  logic [REG_W-1:0]     flushIn;
  logic [REG_W-1:0]     rdMux;

  // mixer requests drag the control-path bit along
  always_comb begin
    flushIn = wdata;
    if (|(wdata & MIXER_MASK)) flushIn[CTL_PATH_BIT] = 1'b1;
  end

  // per-unit gating of the sub-masks by their summary bits
  for (genvar i = 0; i < NUM_INTF; i++) begin : g_intfGate
    assign pendingIntf[i] = intfSub[i] & pendingFlush[INTF_SUM_BIT];
  end
  for (genvar j = 0; j < NUM_MERGE; j++) begin : g_mergeGate
    assign pendingMerge[j] = mergeSub[j] & pendingFlush[MERGE_SUM_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingFlush <= '0;
      intfSub      <= '0;
      mergeSub     <= '0;
    end else if (st.clearAll) begin
      pendingFlush <= '0;
      intfSub      <= '0;
      mergeSub     <= '0;
    end else begin
      pendingFlush <= (st.retire ? '0 : pendingFlush) |
                      (st.wrFlush ? flushIn : '0);
      intfSub      <= (st.retire ? '0 : intfSub) |
                      (st.wrIntfSub ? wdata[NUM_INTF-1:0] : '0);
      mergeSub     <= (st.retire ? '0 : mergeSub) |
                      (st.wrMergeSub ? wdata[NUM_MERGE-1:0] : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushApply   <= 1'b0;
      appliedFlush <= '0;
      appliedIntf  <= '0;
      appliedMerge <= '0;
    end else begin
      flushApply <= st.retire && !st.clearAll && (pendingFlush != '0);
      if (st.retire && !st.clearAll && (pendingFlush != '0)) begin
        appliedFlush <= pendingFlush;
        appliedIntf  <= pendingIntf;
        appliedMerge <= pendingMerge;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topCfg      <= '0;
      intfActive  <= '0;
      mergeActive <= '0;
      fetchActive <= '0;
      intfMaster  <= '0;
    end else begin
      if (st.wrTop)      topCfg      <= wdata;
      if (st.wrIntfAct)  intfActive  <= wdata[NUM_INTF-1:0];
      if (st.wrMergeAct) mergeActive <= wdata[NUM_MERGE-1:0];
      if (st.wrFetch)    fetchActive <= wdata;
      if (st.wrMaster)   intfMaster  <= wdata;
    end
  end

  assign cmdMode = topCfg[CMD_MODE_BIT];

  always_comb begin
    rdMux = '0;
    if (busAddr == ADDR_W'(OFF_TOP))            rdMux = topCfg;
    else if (busAddr == ADDR_W'(OFF_FLUSH))     rdMux = pendingFlush;
    else if (busAddr == ADDR_W'(OFF_SWRST))     rdMux = REG_W'(resetBusy);
    else if (busAddr == ADDR_W'(OFF_MERGE_ACT)) rdMux = REG_W'(mergeActive);
    else if (busAddr == ADDR_W'(OFF_INTF_ACT))  rdMux = REG_W'(intfActive);
    else if (busAddr == ADDR_W'(OFF_FETCH_ACT)) rdMux = fetchActive;
    else if (busAddr == ADDR_W'(OFF_MERGE_SUB)) rdMux = REG_W'(mergeSub);
    else if (busAddr == ADDR_W'(OFF_INTF_SUB))  rdMux = REG_W'(intfSub);
    else if (busAddr == ADDR_W'(OFF_MASTER))    rdMux = intfMaster;
  end

  always_ff @(posedge clk) begin
    if (!rstN)      busRdata <= '0;
    else if (busRd) busRdata <= rdMux;
    else            busRdata <= '0;
  end

  logic retireQ, clearQ;
  assign retireQ = st.retire;
  assign clearQ  = st.clearAll;

  // R2: pending bits only drop on retire or software reset
  a_r2_accumulate: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(retireQ) && !$past(clearQ)) |->
      ((pendingFlush & $past(pendingFlush)) == $past(pendingFlush)));

  // R3: a pending mixer bit always carries the control-path bit
  a_r3_mixer_ctl: assert property (@(posedge clk) disable iff (!rstN)
    (|(pendingFlush & MIXER_MASK)) |-> pendingFlush[CTL_PATH_BIT]);

  // R4: gated sub-masks need their summary bits
  a_r4_intf_gated: assert property (@(posedge clk) disable iff (!rstN)
    (|pendingIntf) |-> pendingFlush[INTF_SUM_BIT]);
  a_r4_merge_gated: assert property (@(posedge clk) disable iff (!rstN)
    (|pendingMerge) |-> pendingFlush[MERGE_SUM_BIT]);

  // R5: the strobe always carries a nonzero mask
  a_r5_apply_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    flushApply |-> (appliedFlush != '0));

  // R10: nothing pending while the reset is busy
  a_r10_busy_empty: assert property (@(posedge clk) disable iff (!rstN)
    resetBusy |-> (pendingFlush == '0 && intfSub == '0 && mergeSub == '0));

endmodule

// File: rtl/flush_ctl.sv
module flush_ctl
  import flush_ctl_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int NUM_INTF     = 8,
  parameter int NUM_MERGE    = 4,
  parameter int RESET_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic                 frameDone,
  output logic [31:0]          pendingFlush,
  output logic [NUM_INTF-1:0]  pendingIntf,
  output logic [NUM_MERGE-1:0] pendingMerge,
  output logic                 flushApply,
  output logic [31:0]          appliedFlush,
  output logic [NUM_INTF-1:0]  appliedIntf,
  output logic [NUM_MERGE-1:0] appliedMerge,
  output logic                 startPulse,
  output logic                 preparePulse,
  output logic                 resetBusy,
  output logic                 cmdMode,
  output logic [NUM_INTF-1:0]  intfActive,
  output logic [NUM_MERGE-1:0] mergeActive,
  output logic [31:0]          fetchActive,
  output logic [31:0]          intfMaster
);

  strobes_t st;

  flush_ctl_ctrl #(
    .ADDR_W      (ADDR_W),
    .RESET_CYCLES(RESET_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busWr       (busWr),
    .busAddr     (busAddr),
    .wrBit0      (busWdata[0]),
    .frameDone   (frameDone),
    .st          (st),
    .resetBusy   (resetBusy),
    .startPulse  (startPulse),
    .preparePulse(preparePulse)
  );

  flush_ctl_dp #(
    .ADDR_W   (ADDR_W),
    .NUM_INTF (NUM_INTF),
    .NUM_MERGE(NUM_MERGE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .wdata       (busWdata),
    .busRd       (busRd),
    .busAddr     (busAddr),
    .resetBusy   (resetBusy),
    .busRdata    (busRdata),
    .pendingFlush(pendingFlush),
    .pendingIntf (pendingIntf),
    .pendingMerge(pendingMerge),
    .flushApply  (flushApply),
    .appliedFlush(appliedFlush),
    .appliedIntf (appliedIntf),
    .appliedMerge(appliedMerge),
    .cmdMode     (cmdMode),
    .intfActive  (intfActive),
    .mergeActive (mergeActive),
    .fetchActive (fetchActive),
    .intfMaster  (intfMaster)
  );

endmodule

// File: tb/flush_ctl_tb.sv
module flush_ctl_tb;

  localparam int ADDR_W  = 12;
  localparam int N_INTF  = 8;
  localparam int N_MERGE = 4;
  localparam int RST_CYC = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic frameDone = 1'b0;
  logic [31:0] busRdata, pendingFlush, appliedFlush, fetchActive, intfMaster;
  logic [N_INTF-1:0] pendingIntf, appliedIntf, intfActive;
  logic [N_MERGE-1:0] pendingMerge, appliedMerge, mergeActive;
  logic flushApply, startPulse, preparePulse, resetBusy, cmdMode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flush_ctl #(
    .ADDR_W(ADDR_W), .NUM_INTF(N_INTF), .NUM_MERGE(N_MERGE), .RESET_CYCLES(RST_CYC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .frameDone(frameDone),
    .pendingFlush(pendingFlush), .pendingIntf(pendingIntf), .pendingMerge(pendingMerge),
    .flushApply(flushApply), .appliedFlush(appliedFlush), .appliedIntf(appliedIntf),
    .appliedMerge(appliedMerge), .startPulse(startPulse), .preparePulse(preparePulse),
    .resetBusy(resetBusy), .cmdMode(cmdMode), .intfActive(intfActive),
    .mergeActive(mergeActive), .fetchActive(fetchActive), .intfMaster(intfMaster)
  );

  // entry: {isWrite, addr[11:0], data[31:0], expectedRead[31:0]}
  localparam int NV = 27;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h018, 32'h0000_0001, 32'h0},           // R2
    {1'b0, 12'h018, 32'h0, 32'h0000_0001},           // R2
    {1'b1, 12'h018, 32'h0000_0040, 32'h0},           // R3 mixer 0
    {1'b0, 12'h018, 32'h0, 32'h0002_0041},           // R3
    {1'b1, 12'h018, 32'h0010_0000, 32'h0},           // R3 mixer 5
    {1'b0, 12'h018, 32'h0, 32'h0012_0041},           // R3
    {1'b1, 12'h110, 32'h0000_0003, 32'h0},           // R4
    {1'b1, 12'h110, 32'h0000_0010, 32'h0},           // R4
    {1'b0, 12'h110, 32'h0, 32'h0000_0013},           // R4
    {1'b1, 12'h100, 32'h0000_0005, 32'h0},           // R4
    {1'b0, 12'h100, 32'h0, 32'h0000_0005},           // R4
    {1'b1, 12'h014, 32'h0002_0000, 32'h0},           // R8
    {1'b0, 12'h014, 32'h0, 32'h0002_0000},           // R8
    {1'b1, 12'h0F4, 32'hFFFF_FFFF, 32'h0},           // R9
    {1'b0, 12'h0F4, 32'h0, 32'h0000_00FF},           // R9
    {1'b1, 12'h0E4, 32'h0000_00FF, 32'h0},           // R9
    {1'b0, 12'h0E4, 32'h0, 32'h0000_000F},           // R9
    {1'b1, 12'h0FC, 32'h000F_000F, 32'h0},           // R9
    {1'b0, 12'h0FC, 32'h0, 32'h000F_000F},           // R9
    {1'b1, 12'h134, 32'h0000_0001, 32'h0},           // R9
    {1'b0, 12'h134, 32'h0, 32'h0000_0001},           // R9
    {1'b0, 12'h01C, 32'h0, 32'h0},                   // R7
    {1'b0, 12'h0D0, 32'h0, 32'h0},                   // R7
    {1'b0, 12'h030, 32'h0, 32'h0},                   // R10
    {1'b0, 12'h200, 32'h0, 32'h0},                   // R12
    {1'b0, 12'h004, 32'h0, 32'h0},                   // R12
    {1'b0, 12'h018, 32'h0, 32'h0012_0041}            // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    int t0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pending", pendingFlush, 32'h0);
    check("R1 pulses", {29'h0, flushApply, startPulse, preparePulse}, 32'h0);
    check("R1 regs", {resetBusy, cmdMode, 22'h0, intfActive}, 32'h0);
    busRead(12'h018, rd);
    check("R1 read flush", rd, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) busWrite(VEC[i][75:64], VEC[i][63:32]);
      else begin
        busRead(VEC[i][75:64], rd);
        check($sformatf("R2/R12 vector %0d", i), rd, VEC[i][31:0]);
      end
    end
    check("R8 cmdMode", {31'h0, cmdMode}, 32'h1);
    check("R9 intfActive", {24'h0, intfActive}, 32'hFF);
    check("R9 mergeActive", {28'h0, mergeActive}, 32'hF);
    check("R9 fetchActive", fetchActive, 32'h000F_000F);
    check("R4 gated intf off", {24'h0, pendingIntf}, 32'h0);
    check("R4 gated merge off", {28'h0, pendingMerge}, 32'h0);

    // R4 summary bits enable the sub-masks
    busWrite(12'h018, 32'h8080_0000);
    check("R2 pending", pendingFlush, 32'h8092_0041);
    check("R4 gated intf on", {24'h0, pendingIntf}, 32'h13);
    check("R4 gated merge on", {28'h0, pendingMerge}, 32'h5);

    // R5 retire
    @(negedge clk); frameDone = 1'b1;
    @(negedge clk); frameDone = 1'b0;
    check("R5 strobe", {31'h0, flushApply}, 32'h1);
    check("R5 applied", appliedFlush, 32'h8092_0041);
    check("R5 applied intf", {24'h0, appliedIntf}, 32'h13);
    check("R5 applied merge", {28'h0, appliedMerge}, 32'h5);
    check("R5 cleared", pendingFlush, 32'h0);
    busRead(12'h110, rd);
    check("R5 sub cleared", rd, 32'h0);
    check("R5 strobe one cycle", {31'h0, flushApply}, 32'h0);
    @(negedge clk); frameDone = 1'b1;
    @(negedge clk); frameDone = 1'b0;
    check("R5 no strobe when empty", {31'h0, flushApply}, 32'h0);

    // R6 write racing frameDone
    busWrite(12'h018, 32'h0000_0002);
    @(negedge clk);
    busWr = 1'b1; busAddr = 12'h018; busWdata = 32'h4; frameDone = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0; frameDone = 1'b0;
    check("R6 applied old", appliedFlush, 32'h2);
    check("R6 strobe", {31'h0, flushApply}, 32'h1);
    check("R6 new pending", pendingFlush, 32'h4);

    // R7 triggers
    busWrite(12'h01C, 32'h1);
    check("R7 start", {31'h0, startPulse}, 32'h1);
    @(negedge clk);
    check("R7 start one cycle", {31'h0, startPulse}, 32'h0);
    busWrite(12'h0D0, 32'h1);
    check("R7 prepare", {31'h0, preparePulse}, 32'h1);
    busWrite(12'h01C, 32'h2);
    check("R7 bit0 clear", {31'h0, startPulse}, 32'h0);

    // R10 software reset
    busWrite(12'h110, 32'h1);
    busWrite(12'h030, 32'h1);
    t0 = cyc;
    check("R10 busy", {31'h0, resetBusy}, 32'h1);
    check("R10 cleared", pendingFlush, 32'h0);
    // R11 writes ignored while busy
    busWrite(12'h018, 32'h1);
    check("R11 flush ignored", pendingFlush, 32'h0);
    busWrite(12'h110, 32'h2);
    busWrite(12'h01C, 32'h1);
    check("R11 start ignored", {31'h0, startPulse}, 32'h0);
    busWrite(12'h0D0, 32'h1);
    check("R11 prepare honored", {31'h0, preparePulse}, 32'h1);
    busRead(12'h110, rd);
    check("R11 sub ignored", rd, 32'h0);
    busRead(12'h030, rd);
    check("R10 status reads busy", rd, 32'h1);
    while (resetBusy) @(negedge clk);
    check("R10 busy length", cyc - t0, RST_CYC);
    busRead(12'h030, rd);
    check("R10 status idle", rd, 32'h0);
    busWrite(12'h018, 32'h1);
    check("R11 flush after busy", pendingFlush, 32'h1);

    finishRun();
  end

endmodule